// File: doc/BRIEF.md
# Three-Timebase System Timer

This block keeps three independent 32-bit unsigned counters that all run off one system clock. A microsecond counter runs freely and serves as a time-stamp source. A millisecond interval timer counts a programmed number of milliseconds down to zero and then signals the end of the interval. A time-of-day counter advances once every tenth of a second. The microsecond, millisecond and tenth-second enables come from a chain of three divide stages. Each stage's ratio is a parameter, so the same block serves any system clock frequency that is a whole number of megahertz.

Software reaches the unit through a small register port. A write takes effect at the next clock edge. A read returns a registered snapshot of the addressed register, with a valid strobe, one cycle after the request. Each of the three timer events sets its own sticky flag, and each flag has an enable bit. The single interrupt output is active while any enabled flag is set.

The interval timer is a two-state machine. In IVL_IDLE it waits for a start command. The transition START (start command with a non-zero load value) moves it to IVL_RUN and loads the counter. In IVL_RUN, each millisecond enable decrements the count, and a new start command restarts the count from the load value. When the count steps from one to zero, EXPIRE sets the interval flag. After EXPIRE the machine either reloads and stays in IVL_RUN (periodic mode) or returns to IVL_IDLE with the count at zero (one-shot mode). A stop command takes the transition HALT back to IVL_IDLE and freezes the count.

Top module: `systimer`

## Requirements
- R1: The microsecond counter (address 0) increments by one exactly once every SYS_PER_US clocks and holds its value otherwise. The millisecond enable fires once every US_PER_MS microsecond enables, and the tenth-second enable fires once every MS_PER_TENTH millisecond enables. After reset every register reads zero, and the port's rdata and rd_valid outputs are zero.
- R2: When the microsecond counter steps from 0xFFFFFFFF it becomes 0 and sets flag bit 0.
- R3: A software write to the microsecond counter (address 0) or the time-of-day counter (address 3) takes priority over an increment in the same cycle. The written value appears unchanged at the next edge.
- R4: Writing 1 to bit 0 of the control register (address 4) while the load register (address 1) is non-zero starts the interval timer. The current count (address 2, read-only) is loaded with the load value and decrements on each millisecond enable. When it steps from 1 to 0, flag bit 1 is set. In one-shot mode (control bit 1 = 0) the timer then stops with a count of 0. Control read-back: bit 0 = running, bit 1 = mode.
- R5: In periodic mode (control bit 1 = 1), expiry reloads the count from the load register and the timer keeps running.
- R6: Writing 1 to control bit 2 stops the timer and freezes its count; a stop wins over a start in the same write. A start while the load register is zero has no effect. While the timer is stopped, its count does not change.
- R7: The time-of-day counter (address 3) increments on every tenth-second enable, and each such enable sets flag bit 2.
- R8: The flag register (address 5) holds bits 2:0. A flag stays set until software writes a 1 to that bit, and a flag set in the same cycle as its clear stays set.
- R9: The irq output is high exactly when some flag bit is set whose enable bit in the enable register (address 6, bits 2:0) is also set.
- R10: A read request (rd_en) produces rd_valid and the full 32-bit value, as it stood in the request cycle, one cycle later. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request for the register at addr |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | rdata holds the answer to the previous cycle's request |
| irq | output | 1 | OR of the enabled pending flags |

## Verification
Every result in this block becomes visible one clock edge after its cause. Read data and the valid strobe arrive one edge after rd_en and capture the value from the request cycle. Counter and flag updates, and therefore irq, follow one edge after the enable or write that causes them. The bench keeps a cycle-accurate reference model of the timebases, counters, interval machine and flags, updated at the same edge as the design. A read pushes the model's value for that request cycle into a queue, and the monitor pops it on the falling edge after rd_valid rises. irq is compared against the model on every falling edge.

// File: rtl/systimer_pkg.sv
package systimer_pkg;

    localparam int unsigned CNT_W  = 32;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned NFLAG  = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_USEC  = 3'd0,
        RA_LOAD  = 3'd1,
        RA_COUNT = 3'd2,
        RA_TOD   = 3'd3,
        RA_CTRL  = 3'd4,
        RA_FLAG  = 3'd5,
        RA_IEN   = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        IVL_IDLE = 1'b0,
        IVL_RUN  = 1'b1
    } ivl_state_e;

    // flag bit positions
    localparam int unsigned FB_WRAP = 0;
    localparam int unsigned FB_IVL  = 1;
    localparam int unsigned FB_TOD  = 2;

    // control bit positions
    localparam int unsigned CB_START = 0;
    localparam int unsigned CB_MODE  = 1;
    localparam int unsigned CB_STOP  = 2;

endpackage

// File: rtl/systimer_divstage.sv
module systimer_divstage #(
    parameter int unsigned RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_out
);
    localparam int unsigned W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [W-1:0] LAST = W'(RATIO - 1);

    logic [W-1:0] cnt_q;
    logic         at_last;

    assign at_last = (cnt_q == LAST);
    assign en_out  = en_in && at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_in) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/systimer_upcnt.sv
module systimer_upcnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [W-1:0] val_q;

    assign value = val_q;
    assign wrap  = step && !load_en && (&val_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (load_en) begin
            val_q <= load_val;
        end else if (step) begin
            val_q <= val_q + 1'b1;
        end
    end
endmodule

// File: rtl/systimer_ivl.sv
module systimer_ivl
    import systimer_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ms_tick,
    input  logic         start,
    input  logic         stop,
    input  logic         periodic,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         running,
    output logic         expire
);
    ivl_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         load_ok;
    logic         last_ms;

    assign load_ok = (load_val != '0);
    assign last_ms = (cnt_q == W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IVL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            IVL_IDLE: begin
                if (start && !stop && load_ok) begin
                    state_d = IVL_RUN;
                    cnt_d   = load_val;
                end
            end
            IVL_RUN: begin
                if (stop) begin
                    state_d = IVL_IDLE;
                end else if (start && load_ok) begin
                    cnt_d = load_val;
                end else if (ms_tick) begin
                    if (last_ms) begin
                        expire = 1'b1;
                        if (periodic && load_ok) begin
                            cnt_d = load_val;
                        end else begin
                            cnt_d   = '0;
                            state_d = IVL_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: state_d = IVL_IDLE;
        endcase
    end

    assign count   = cnt_q;
    assign running = (state_q == IVL_RUN);
endmodule

// File: rtl/systimer.sv
module systimer
    import systimer_pkg::*;
#(
    parameter int unsigned SYS_PER_US   = 4,
    parameter int unsigned US_PER_MS    = 1000,
    parameter int unsigned MS_PER_TENTH = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        rd_valid,
    output logic        irq
);
    localparam int unsigned NSTAGE = 3;
    localparam int unsigned RATIOS [NSTAGE] = '{SYS_PER_US, US_PER_MS, MS_PER_TENTH};

    reg_addr_e          ra;
    logic [NSTAGE:0]    en_chain;
    logic               us_tick, ms_tick, tn_tick;
    logic               wr_tick, wr_tod, wr_load, wr_ctrl, wr_flag, wr_ien;
    logic [CNT_W-1:0]   tick_q, tod_q, load_q, ivl_cnt;
    logic               tick_wrap, tod_wrap_unused;
    logic               periodic_q, ivl_start, ivl_stop, ivl_running, ivl_expire;
    logic [NFLAG-1:0]   flags_q, flag_set, flag_clr, irq_en_q;
    logic [CNT_W-1:0]   rd_mux, rdata_q;
    logic               rd_valid_q;

    assign ra = reg_addr_e'(addr);

    // prescaler chain
    assign en_chain[0] = 1'b1;
    for (genvar g = 0; g < NSTAGE; g++) begin : g_div
        systimer_divstage #(.RATIO(RATIOS[g])) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_in  (en_chain[g]),
            .en_out (en_chain[g+1])
        );
    end
    assign us_tick = en_chain[1];
    assign ms_tick = en_chain[2];
    assign tn_tick = en_chain[3];

    // write decode
    assign wr_tick = wr_en && (ra == RA_USEC);
    assign wr_load = wr_en && (ra == RA_LOAD);
    assign wr_tod  = wr_en && (ra == RA_TOD);
    assign wr_ctrl = wr_en && (ra == RA_CTRL);
    assign wr_flag = wr_en && (ra == RA_FLAG);
    assign wr_ien  = wr_en && (ra == RA_IEN);

    assign ivl_start = wr_ctrl && wdata[CB_START];
    assign ivl_stop  = wr_ctrl && wdata[CB_STOP];

    systimer_upcnt #(.W(CNT_W)) u_usec (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (us_tick),
        .load_en  (wr_tick),
        .load_val (wdata),
        .value    (tick_q),
        .wrap     (tick_wrap)
    );

    systimer_upcnt #(.W(CNT_W)) u_tod (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tn_tick),
        .load_en  (wr_tod),
        .load_val (wdata),
        .value    (tod_q),
        .wrap     (tod_wrap_unused)
    );

    systimer_ivl #(.W(CNT_W)) u_ivl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .start    (ivl_start),
        .stop     (ivl_stop),
        .periodic (periodic_q),
        .load_val (load_q),
        .count    (ivl_cnt),
        .running  (ivl_running),
        .expire   (ivl_expire)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q     <= '0;
            periodic_q <= 1'b0;
            irq_en_q   <= '0;
        end else begin
            if (wr_load) load_q     <= wdata;
            if (wr_ctrl) periodic_q <= wdata[CB_MODE];
            if (wr_ien)  irq_en_q   <= wdata[NFLAG-1:0];
        end
    end

    // sticky flags: set beats clear
    always_comb begin
        flag_set          = '0;
        flag_set[FB_WRAP] = tick_wrap;
        flag_set[FB_IVL]  = ivl_expire;
        flag_set[FB_TOD]  = tn_tick;
        flag_clr          = wr_flag ? wdata[NFLAG-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    assign irq = |(flags_q & irq_en_q);

    // read port: whole-word snapshot
    always_comb begin
        rd_mux = '0;
        unique case (ra)
            RA_USEC:  rd_mux = tick_q;
            RA_LOAD:  rd_mux = load_q;
            RA_COUNT: rd_mux = ivl_cnt;
            RA_TOD:   rd_mux = tod_q;
            RA_CTRL:  rd_mux = CNT_W'({periodic_q, ivl_running});
            RA_FLAG:  rd_mux = CNT_W'(flags_q);
            RA_IEN:   rd_mux = CNT_W'(irq_en_q);
            RA_NONE:  rd_mux = '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) rdata_q <= rd_mux;
        end
    end

    assign rdata    = rdata_q;
    assign rd_valid = rd_valid_q;
endmodule

// File: rtl/systimer_chk.sv
module systimer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        rd_valid,
    input logic        us_tick,
    input logic        tn_tick,
    input logic        wr_tick,
    input logic        wr_tod,
    input logic [31:0] tick_q,
    input logic [2:0]  flags_q,
    input logic [2:0]  flag_clr,
    input logic        ivl_running,
    input logic        ivl_start,
    input logic [31:0] ivl_cnt
);
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R10

    AST_USEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !wr_tick) |=> $stable(tick_q)); // R1

    AST_USEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (us_tick && !wr_tick && (&tick_q)) |=> (tick_q == 32'd0 && flags_q[0])); // R2

    AST_TOD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tn_tick && !wr_tod) |=> flags_q[2]); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[1] && !flag_clr[1]) |=> flags_q[1]); // R8

    AST_IVL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ivl_running && !ivl_start) |=> $stable(ivl_cnt)); // R6

    AST_IVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_running |-> (ivl_cnt != 32'd0)); // R4
endmodule

bind systimer systimer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .us_tick     (us_tick),
    .tn_tick     (tn_tick),
    .wr_tick     (wr_tick),
    .wr_tod      (wr_tod),
    .tick_q      (tick_q),
    .flags_q     (flags_q),
    .flag_clr    (flag_clr),
    .ivl_running (ivl_running),
    .ivl_start   (ivl_start),
    .ivl_cnt     (ivl_cnt)
);

// File: tb/systimer_bench.sv
module systimer_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned P_US = 2;
    localparam int unsigned P_MS = 5;
    localparam int unsigned P_TN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    systimer #(.SYS_PER_US(P_US), .US_PER_MS(P_MS), .MS_PER_TENTH(P_TN)) u_systimer (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq(irq)
    );

    // ---------------- reference model ----------------
    int unsigned m_us, m_ms, m_tn;
    logic [31:0] m_tick, m_tod, m_load, m_cnt;
    logic        m_run, m_per;
    logic [2:0]  m_flags, m_ien, clr;
    logic        us_t, ms_t, tn_t, wrap, expd, st, sp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_us <= 0; m_ms <= 0; m_tn <= 0;
            m_tick <= 0; m_tod <= 0; m_load <= 0; m_cnt <= 0;
            m_run <= 0; m_per <= 0; m_flags <= 0; m_ien <= 0;
        end else begin
            us_t = (m_us == P_US-1);
            ms_t = us_t && (m_ms == P_MS-1);
            tn_t = ms_t && (m_tn == P_TN-1);
            m_us <= us_t ? 0 : m_us + 1;
            if (us_t) m_ms <= (m_ms == P_MS-1) ? 0 : m_ms + 1;
            if (ms_t) m_tn <= (m_tn == P_TN-1) ? 0 : m_tn + 1;
            wrap = 1'b0;
            if (wr_en && addr == 3'd0) m_tick <= wdata;
            else if (us_t) begin
                m_tick <= m_tick + 1;
                wrap = (m_tick == 32'hFFFF_FFFF);
            end
            if (wr_en && addr == 3'd3) m_tod <= wdata;
            else if (tn_t) m_tod <= m_tod + 1;
            if (wr_en && addr == 3'd1) m_load <= wdata;
            st = wr_en && addr == 3'd4 && wdata[0];
            sp = wr_en && addr == 3'd4 && wdata[2];
            if (wr_en && addr == 3'd4) m_per <= wdata[1];
            expd = 1'b0;
            if (!m_run) begin
                if (st && !sp && m_load != 0) begin m_run <= 1; m_cnt <= m_load; end
            end else if (sp) m_run <= 0;
            else if (st && m_load != 0) m_cnt <= m_load;
            else if (ms_t) begin
                if (m_cnt == 1) begin
                    expd = 1'b1;
                    if (m_per && m_load != 0) m_cnt <= m_load;
                    else begin m_cnt <= 0; m_run <= 0; end
                end else m_cnt <= m_cnt - 1;
            end
            if (wr_en && addr == 3'd6) m_ien <= wdata[2:0];
            clr = (wr_en && addr == 3'd5) ? wdata[2:0] : 3'd0;
            m_flags <= (m_flags & ~clr) | {tn_t, expd, wrap};
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_tick;
            3'd1: return m_load;
            3'd2: return m_cnt;
            3'd3: return m_tod;
            3'd4: return {30'd0, m_per, m_run};
            3'd5: return {29'd0, m_flags};
            3'd6: return {29'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sbq[$];

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        item_t it;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        it.exp = m_read(a); it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: read data and irq
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_valid) begin
                if (sbq.size() == 0) check(1'b0, "R10 unexpected valid", {31'd0, rd_valid}, 32'd0);
                else begin
                    item_t it;
                    it = sbq.pop_front();
                    check(rdata === it.exp, it.tag, rdata, it.exp);
                end
            end
            check(irq === |(m_flags & m_ien), "R9 irq", {31'd0, irq}, {31'd0, |(m_flags & m_ien)});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdata === 32'd0 && rd_valid === 1'b0, "R1 reset port", rdata, 32'd0);
        rd(3'd5, "R1 reset flags");
        rd(3'd4, "R1 reset ctrl");
        rd(3'd6, "R1 reset ien");
        rd(3'd0, "R1 usec early");
        idle(7);
        rd(3'd0, "R1 usec later");
        rd(3'd7, "R10 empty address");
        // R3 write priority over steps, several phases
        for (int i = 0; i < 4; i++) begin
            wr(3'd0, 32'h1000_0000 + i);
            rd(3'd0, "R3 usec write");
        end
        // R2 wrap
        wr(3'd0, 32'hFFFF_FFF8);
        idle(24);
        rd(3'd0, "R2 usec after wrap");
        rd(3'd5, "R2 wrap flag");
        wr(3'd6, 32'd1);
        idle(2);
        rd(3'd6, "R9 enable");
        wr(3'd5, 32'd1);
        rd(3'd5, "R8 cleared");
        // R4 one-shot
        wr(3'd1, 32'd3);
        wr(3'd4, 32'h1);
        rd(3'd4, "R4 running");
        rd(3'd2, "R4 count");
        idle(12);
        rd(3'd2, "R4 count mid");
        idle(30);
        rd(3'd2, "R4 count done");
        rd(3'd4, "R4 stopped");
        rd(3'd5, "R4 ivl flag");
        wr(3'd6, 32'd2);
        idle(3);
        // R8 hammer clears
        for (int i = 0; i < 20; i++) wr(3'd5, 32'd7);
        rd(3'd5, "R8 set beats clear");
        // R5 periodic
        wr(3'd1, 32'd2);
        wr(3'd4, 32'h3);
        idle(45);
        rd(3'd4, "R5 still running");
        rd(3'd2, "R5 reloaded count");
        rd(3'd5, "R5 flag");
        // R6 stop freezes
        wr(3'd4, 32'h6);
        rd(3'd2, "R6 frozen count a");
        idle(25);
        rd(3'd2, "R6 frozen count b");
        rd(3'd4, "R6 stopped");
        wr(3'd4, 32'h5);
        rd(3'd4, "R6 stop beats start");
        wr(3'd1, 32'd0);
        wr(3'd4, 32'h1);
        rd(3'd4, "R6 zero load start ignored");
        // R7 time of day
        wr(3'd5, 32'd7);
        wr(3'd3, 32'd41);
        rd(3'd3, "R3 tod write");
        wr(3'd6, 32'd4);
        idle(45);
        rd(3'd3, "R7 tod advanced");
        rd(3'd5, "R7 tod flag");
        idle(4);
        done = 1'b1;
        if (sbq.size() != 0) check(1'b0, "R10 missing responses", sbq.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule